// File: doc/BRIEF.md
# Five-Digit Multiplexed Seven-Segment Scanner

This block drives five seven-segment digits that share one set of segment lines. Two of the digits show a win amount and three show a total credit count. All five arrive as 4-bit BCD values. Only one digit is lit at any moment. A prescaler divides the system clock into a slow step pulse, and each step moves a digit counter on to the next digit. The counter wraps after the fifth digit.

For the digit that is currently selected, the block drives a one-hot, active-low enable. It also drives the 7-bit segment pattern for a common-cathode display, decoded combinationally from that digit's BCD value. With the default prescale limit and a 25.5 MHz clock, each digit is lit for 100,000 cycles. That is about 3.9 ms, so each digit is refreshed at roughly 51 Hz and the whole scan has no visible flicker. The values are loaded, and converted from binary to BCD, outside this block.

Top module: `seg_scan_driver`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the prescaler and the digit counter are zero. Slot 0 is selected, so `digit_en_n` is 5'b11110.
- R2: The digit counter advances exactly once every PRESCALE_MAX+1 clock cycles. The default limit of 99,999 gives 100,000 cycles per digit.
- R3: Slots map to digits as follows: slot 0 is `win_bcd[3:0]` (win digit 1), slot 1 is `win_bcd[7:4]`, slot 2 is `credit_bcd[3:0]` (credit digit 1), slot 3 is `credit_bcd[7:4]` and slot 4 is `credit_bcd[11:8]`. Slot i drives bit i of `digit_en_n` low.
- R4: After slot 4 the digit counter returns to slot 0, and it never holds a value above 4.
- R5: `digit_en_n` always has exactly one bit low.
- R6: `seg` bit order is {g,f,e,d,c,b,a}, and a lit segment is 1. The digits decode to these hex patterns: 0 is 3F, 1 is 06, 2 is 5B, 3 is 4F, 4 is 66, 5 is 6D, 6 is 7D, 7 is 07, 8 is 7F and 9 is 6F.
- R7: BCD values from 10 to 15 decode to `seg` = 7'h00, with every segment dark.
- R8: `seg` follows a change of the selected digit's input within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| win_bcd | input | 8 | Win amount: two BCD digits, with digit 1 in bits [3:0] |
| credit_bcd | input | 12 | Total credits: three BCD digits, with digit 1 in bits [3:0] |
| digit_en_n | output | 5 | One-hot, active-low digit enable |
| seg | output | 7 | Segment pattern {g,f,e,d,c,b,a}, active high |

## Verification
The first pattern sets every digit to a different value, so a digit routed to the wrong slot cannot go unnoticed. The second pattern mixes 8 and 0, which light all segments and all but the middle segment. This makes a swapped or stuck segment bit stand out. The third pattern places values from 10 to 15 among valid digits, which separates the blanking decode from a decoder that only wraps the value. The last pattern is all nines. Each pattern is checked cycle by cycle over six dwell periods, so the bench catches an off-by-one dwell length and a wrong wrap as well as the digit order.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    localparam int BCD_W         = 4;
    localparam int WIN_DIGITS    = 2;
    localparam int CREDIT_DIGITS = 3;
    localparam int NUM_SLOTS     = WIN_DIGITS + CREDIT_DIGITS;
    localparam int SLOT_W        = $clog2(NUM_SLOTS);
    localparam int SEG_W         = 7;
    localparam int WIN_W         = WIN_DIGITS * BCD_W;
    localparam int CREDIT_W      = CREDIT_DIGITS * BCD_W;

    typedef logic [BCD_W-1:0]  bcd_t;
    typedef logic [SLOT_W-1:0] slot_t;

    // Segment lines, MSB first: g f e d c b a, with 1 meaning lit
    typedef struct packed {
        logic g;
        logic f;
        logic e;
        logic d;
        logic c;
        logic b;
        logic a;
    } seg_t;

    // BCD to common-cathode pattern; codes 10..15 stay dark
    function automatic seg_t bcd_to_seg(input bcd_t v);
        seg_t s;
        s = '0;
        unique case (v)
            4'd0: s = '{g:1'b0, f:1'b1, e:1'b1, d:1'b1, c:1'b1, b:1'b1, a:1'b1};
            4'd1: s = '{g:1'b0, f:1'b0, e:1'b0, d:1'b0, c:1'b1, b:1'b1, a:1'b0};
            4'd2: s = '{g:1'b1, f:1'b0, e:1'b1, d:1'b1, c:1'b0, b:1'b1, a:1'b1};
            4'd3: s = '{g:1'b1, f:1'b0, e:1'b0, d:1'b1, c:1'b1, b:1'b1, a:1'b1};
            4'd4: s = '{g:1'b1, f:1'b1, e:1'b0, d:1'b0, c:1'b1, b:1'b1, a:1'b0};
            4'd5: s = '{g:1'b1, f:1'b1, e:1'b0, d:1'b1, c:1'b1, b:1'b0, a:1'b1};
            4'd6: s = '{g:1'b1, f:1'b1, e:1'b1, d:1'b1, c:1'b1, b:1'b0, a:1'b1};
            4'd7: s = '{g:1'b0, f:1'b0, e:1'b0, d:1'b0, c:1'b1, b:1'b1, a:1'b1};
            4'd8: s = '{g:1'b1, f:1'b1, e:1'b1, d:1'b1, c:1'b1, b:1'b1, a:1'b1};
            4'd9: s = '{g:1'b1, f:1'b1, e:1'b0, d:1'b1, c:1'b1, b:1'b1, a:1'b1};
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_prescaler.sv
module seg_prescaler #(
    parameter int unsigned PRESCALE_MAX = 99999
) (
    input  logic clk,
    input  logic rst,
    output logic step
);
    localparam int CNT_W = (PRESCALE_MAX < 1) ? 1 : $clog2(PRESCALE_MAX + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PRESCALE_MAX);

    logic [CNT_W-1:0] count;

    assign step = (count == LIMIT);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (step) count <= '0;
        else           count <= count + 1'b1;
    end
endmodule

// File: rtl/seg_slot_counter.sv
module seg_slot_counter
    import seg_scan_pkg::*;
#(
    parameter int N = NUM_SLOTS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output slot_t slot
);
    localparam slot_t LAST = slot_t'(N - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (step)
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
    end
endmodule

// File: rtl/seg_digit_select.sv
module seg_digit_select
    import seg_scan_pkg::*;
(
    input  slot_t                slot,
    input  logic [WIN_W-1:0]     win_bcd,
    input  logic [CREDIT_W-1:0]  credit_bcd,
    output logic [NUM_SLOTS-1:0] digit_en_n,
    output seg_t                 seg
);
    bcd_t digits [NUM_SLOTS];
    bcd_t chosen;

    // Scan order: win digits first, then credit digits, lowest first
    for (genvar w = 0; w < WIN_DIGITS; w++) begin : g_win
        assign digits[w] = win_bcd[w*BCD_W +: BCD_W];
    end
    for (genvar c = 0; c < CREDIT_DIGITS; c++) begin : g_cred
        assign digits[WIN_DIGITS + c] = credit_bcd[c*BCD_W +: BCD_W];
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_en
        assign digit_en_n[i] = (slot != slot_t'(i));
    end

    always_comb begin
        chosen = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (slot == slot_t'(k)) chosen = digits[k];
        end
    end

    assign seg = bcd_to_seg(chosen);
endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver
    import seg_scan_pkg::*;
#(
    parameter int unsigned PRESCALE_MAX = 99999
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WIN_W-1:0]     win_bcd,
    input  logic [CREDIT_W-1:0]  credit_bcd,
    output logic [NUM_SLOTS-1:0] digit_en_n,
    output logic [SEG_W-1:0]     seg
);
    logic  step;
    slot_t slot;
    seg_t  seg_s;

    seg_prescaler #(.PRESCALE_MAX(PRESCALE_MAX)) u_prescale (
        .clk  (clk),
        .rst  (rst),
        .step (step)
    );

    seg_slot_counter #(.N(NUM_SLOTS)) u_slots (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .slot (slot)
    );

    seg_digit_select u_select (
        .slot       (slot),
        .win_bcd    (win_bcd),
        .credit_bcd (credit_bcd),
        .digit_en_n (digit_en_n),
        .seg        (seg_s)
    );

    assign seg = seg_s;
endmodule

// File: rtl/seg_scan_checker.sv
module seg_scan_checker
    import seg_scan_pkg::*;
#(
    parameter int unsigned PRESCALE_MAX = 99999
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 step,
    input slot_t                slot,
    input logic [NUM_SLOTS-1:0] digit_en_n
);
    localparam slot_t LAST = slot_t'(NUM_SLOTS - 1);

    int unsigned gap;

    always_ff @(posedge clk) begin
        if (rst)       gap <= 0;
        else if (step) gap <= 0;
        else           gap <= gap + 1;
    end

    // R1
    reset_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot == '0));

    // R2
    step_period_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> (gap == PRESCALE_MAX));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(slot));

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (slot == (($past(slot) == LAST) ? slot_t'(0) : $past(slot) + 1'b1)));

    // R4
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot <= LAST);

    // R5
    onehot_en_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~digit_en_n) == 1);

    // R3
    en_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !digit_en_n[slot]);
endmodule

bind seg_scan_driver seg_scan_checker #(.PRESCALE_MAX(PRESCALE_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .slot       (slot),
    .digit_en_n (digit_en_n)
);

// File: tb/test_seg_scan_driver.sv
`timescale 1ns/1ps
module test_seg_scan_driver;
    localparam int MAX   = 3;
    localparam int DWELL = MAX + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  win = '0;
    logic [11:0] cred = '0;
    logic [4:0]  en_n;
    logic [6:0]  seg;

    typedef struct {
        logic [4:0] en;
        logic [6:0] sg;
        string      req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    seg_scan_driver #(.PRESCALE_MAX(MAX)) i_seg_scan_driver (
        .clk        (clk),
        .rst        (rst),
        .win_bcd    (win),
        .credit_bcd (cred),
        .digit_en_n (en_n),
        .seg        (seg)
    );

    // R6 table written from the requirement; R7 codes 10..15 blank
    function automatic logic [6:0] exp_seg(input logic [3:0] v);
        case (v)
            4'd0: return 7'h3F;
            4'd1: return 7'h06;
            4'd2: return 7'h5B;
            4'd3: return 7'h4F;
            4'd4: return 7'h66;
            4'd5: return 7'h6D;
            4'd6: return 7'h7D;
            4'd7: return 7'h07;
            4'd8: return 7'h7F;
            4'd9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    // R3 slot to digit mapping
    function automatic logic [3:0] slot_digit(input int s, input logic [7:0] w,
                                              input logic [11:0] c);
        case (s)
            0: return w[3:0];
            1: return w[7:4];
            2: return c[3:0];
            3: return c[7:4];
            default: return c[11:8];
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [11:0] act,
                       input logic [11:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: one expected item per cycle while out of reset
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(en_n == e.en, {e.req, " R5 enable"}, {7'd0, en_n}, {7'd0, e.en});
            chk(seg == e.sg, {e.req, " R6 R7 segments"}, {5'd0, seg}, {5'd0, e.sg});
        end
    end

    // Driver: reset-state checks, then queue six dwell periods of expectations
    task automatic run_pattern(input logic [7:0] w, input logic [11:0] c);
        logic [3:0] alt;
        @(posedge clk); #1;
        rst = 1'b1; win = w; cred = c;
        @(posedge clk); #1;
        chk(en_n == 5'b11110, "R1 reset enable", {7'd0, en_n}, 12'h01E);
        chk(seg == exp_seg(w[3:0]), "R1 reset segments", {5'd0, seg}, {5'd0, exp_seg(w[3:0])});
        alt = (w[3:0] == 4'd8) ? 4'd1 : 4'd8;
        win = {w[7:4], alt};
        #1;
        chk(seg == exp_seg(alt), "R8 same-cycle decode", {5'd0, seg}, {5'd0, exp_seg(alt)});
        win = w;
        #1;
        for (int n = 0; n < 6 * DWELL; n++) begin
            exp_t e;
            int s;
            s = (n / DWELL) % 5;
            e.en = ~(5'b00001 << s);
            e.sg = exp_seg(slot_digit(s, w, c));
            if (n >= 5 * DWELL)              e.req = "R4 wrap";
            else if (n > 0 && n % DWELL == 0) e.req = "R2 step edge";
            else                              e.req = "R3 order";
            q.push_back(e);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #20000;
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        run_pattern(8'h21, 12'h543);  // distinct digits
        run_pattern(8'h80, 12'h808);  // all-lit versus no middle segment
        run_pattern(8'hA7, 12'hF3C);  // R7 invalid codes mixed in
        run_pattern(8'h99, 12'h999);  // uniform nines
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule